// File: doc/BRIEF.md
# Edge/Level Interrupt Request Collector

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Lines 0 to 15 are internal sources. They always trigger on a rising edge and are always active-high. Lines 16 and up are optional external sources; their count is set by the `NUM_EXT` parameter, from 0 to 16. For each external line, the `EXT_EDGE` and `EXT_POL` parameters pick edge or level triggering and active-high or active-low polarity. These choices are fixed at elaboration.

Each line is first turned into an active-high request. A trigger event then latches a status bit. Status ANDed with a software enable mask gives the pending word, and the output is raised whenever any pending bit is set. Software uses a small 32-bit register bus to read status, pending and enable, to write the enable mask, and to acknowledge requests by writing ones to an acknowledge register. Line n always maps to register bit n.

Top module: `irq_collector`

## Requirements
- R1: A synchronous reset clears status and enable, and `irq_out` is low one clock later. An edge line that is already asserted while reset is held produces no status bit once reset is released.
- R2: Internal lines are active-high. An external line whose `EXT_POL` bit is 1 is active-high, and one whose bit is 0 is active-low. Moving a line to its inactive level never sets a status bit.
- R3: For an edge-triggered line, a change from inactive to active sets the status bit at the next clock edge. The bit stays set after the input returns to inactive. A line held active after an acknowledge is not latched again.
- R4: For a level-triggered line (`EXT_EDGE` bit 0), the status bit is set on every clock edge at which the active-high request is asserted.
- R5: Writing the acknowledge register (offset 0x3C) clears exactly the status bits that are written as 1 and are currently set. Ones written to clear bits, and all bits written as 0, leave status unchanged.
- R6: If a level line is still asserted when its bit is acknowledged, that bit reads as set again right after the acknowledge.
- R7: The pending register (offset 0x34) always reads status (offset 0x30) ANDed with enable (offset 0x38). Enable reads back what was last written, restricted to the implemented bits.
- R8: `irq_out` is a register. It is high exactly when status AND enable is nonzero. It changes at the same clock edge that changes status or enable, so an enable write alone can raise or drop it.
- R9: Bits in the reserved mask 0x40008787, and bits at or above 16+`NUM_EXT`, never set in status or enable and read as 0. The acknowledge register reads as 0. Writes to status and pending are ignored.
- R10: If a new trigger event and an acknowledge of the same bit arrive on the same clock edge, the bit stays set.
- R11: Read data is registered. It appears one clock after the read request and reflects the register contents from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16+NUM_EXT | Raw request lines, synchronous to clk |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
An acknowledge write and a new trigger event on the same bit can hit the same clock edge, and the status update has to resolve them. The bench provokes this by applying an acknowledge of two bits on the same falling edge where it raises the inputs of both lines. One of the two bits was already set and the other was clear. The expected result is that both bits read as set afterwards, because a fresh event must never be lost to an acknowledge. A second collision is a read request issued in the same cycle as a new edge. The value returned must be the status from before that edge, and the following read must show the new bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W     = 32;
  localparam int INT_LINES = 16;
  localparam int MAX_EXT   = 16;

  localparam logic [7:0] OFS_STATUS  = 8'h30;
  localparam logic [7:0] OFS_PENDING = 8'h34;
  localparam logic [7:0] OFS_ENABLE  = 8'h38;
  localparam logic [7:0] OFS_ACK     = 8'h3C;

  localparam logic [REG_W-1:0] RSVD_MASK = 32'h4000_8787;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_STATUS,
    RG_PENDING,
    RG_ENABLE,
    RG_ACK
  } irqc_reg_e;

  // Bits that belong to an implemented, non-reserved line.
  function automatic logic [REG_W-1:0] implemented_mask(input int lines);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) begin
      m[i] = (i < lines);
    end
    return m & ~RSVD_MASK;
  endfunction
endpackage

// File: rtl/irqc_line_cond.sv
module irqc_line_cond #(
  parameter bit EDGE_TRIG = 1'b1,
  parameter bit ACT_HIGH  = 1'b1
) (
  input  logic clk,
  input  logic raw,
  output logic evt
);
  logic norm;
  logic prev_q;

  assign norm = ACT_HIGH ? raw : ~raw;

  // Sampled in and out of reset, so a level held through reset is no edge.
  always_ff @(posedge clk) begin
    prev_q <= norm;
  end

  generate
    if (EDGE_TRIG) begin : g_edge
      assign evt = norm & ~prev_q;
    end else begin : g_level
      logic unused_prev;
      assign unused_prev = prev_q;
      assign evt = norm;
    end
  endgenerate
endmodule

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              ack_we,
  output logic              en_we,
  output logic [REG_W-1:0]  wr_bits,
  output logic              rd_req,
  output irqc_reg_e         rd_sel
);
  irqc_reg_e hit;

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_STATUS))       hit = RG_STATUS;
    else if (bus_addr == ADDR_W'(OFS_PENDING)) hit = RG_PENDING;
    else if (bus_addr == ADDR_W'(OFS_ENABLE))  hit = RG_ENABLE;
    else if (bus_addr == ADDR_W'(OFS_ACK))     hit = RG_ACK;
    else                                       hit = RG_NONE;
  end

  assign ack_we  = bus_en && bus_we && (hit == RG_ACK);
  assign en_we   = bus_en && bus_we && (hit == RG_ENABLE);
  assign wr_bits = bus_wdata;
  assign rd_req  = bus_en && !bus_we;
  assign rd_sel  = hit;
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
  import irqc_pkg::*;
#(
  parameter logic [REG_W-1:0] VALID = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] evt,
  input  logic             ack_we,
  input  logic             en_we,
  input  logic [REG_W-1:0] wr_bits,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] enable_q,
  output logic             irq_q
);
  logic [REG_W-1:0] clr;
  logic [REG_W-1:0] status_d;
  logic [REG_W-1:0] enable_d;

  always_comb begin
    clr      = ack_we ? (wr_bits & status_q) : '0;
    // New events are ORed after the clear: a same-edge event survives.
    status_d = ((status_q & ~clr) | evt) & VALID;
    enable_d = en_we ? (wr_bits & VALID) : enable_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq_q    <= |(status_d & enable_d);
    end
  end
endmodule

// File: rtl/irqc_read_port.sv
module irqc_read_port
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  irqc_reg_e        rd_sel,
  input  logic [REG_W-1:0] status_q,
  input  logic [REG_W-1:0] enable_q,
  output logic [REG_W-1:0] rdata_q
);
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    unique case (rd_sel)
      RG_STATUS:  rd_mux = status_q;
      RG_PENDING: rd_mux = status_q & enable_q;
      RG_ENABLE:  rd_mux = enable_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_req) begin
      rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int          NUM_EXT  = 16,
  parameter logic [15:0] EXT_EDGE = 16'h00FF,
  parameter logic [15:0] EXT_POL  = 16'hF0F0,
  parameter int          ADDR_W   = 8,
  localparam int         LINES    = INT_LINES + NUM_EXT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_out
);
  localparam logic [REG_W-1:0] VALID = implemented_mask(LINES);

  logic [REG_W-1:0] evt;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] enable_q;
  logic             ack_we;
  logic             en_we;
  logic [REG_W-1:0] wr_bits;
  logic             rd_req;
  irqc_reg_e        rd_sel;

  generate
    for (genvar i = 0; i < REG_W; i++) begin : g_line
      if (i < INT_LINES) begin : g_int
        irqc_line_cond #(.EDGE_TRIG(1'b1), .ACT_HIGH(1'b1)) cond_i (
          .clk(clk), .raw(irq_in[i]), .evt(evt[i])
        );
      end else if (i < LINES) begin : g_ext
        irqc_line_cond #(
          .EDGE_TRIG(EXT_EDGE[i-INT_LINES]),
          .ACT_HIGH (EXT_POL[i-INT_LINES])
        ) cond_i (
          .clk(clk), .raw(irq_in[i]), .evt(evt[i])
        );
      end else begin : g_absent
        assign evt[i] = 1'b0;
      end
    end
  endgenerate

  irqc_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ack_we(ack_we), .en_we(en_we),
    .wr_bits(wr_bits), .rd_req(rd_req), .rd_sel(rd_sel)
  );

  irqc_status_bank #(.VALID(VALID)) bank_i (
    .clk(clk), .rst(rst), .evt(evt), .ack_we(ack_we), .en_we(en_we),
    .wr_bits(wr_bits), .status_q(status_q), .enable_q(enable_q),
    .irq_q(irq_out)
  );

  irqc_read_port rd_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_sel(rd_sel),
    .status_q(status_q), .enable_q(enable_q), .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int          NUM_EXT  = 16,
  parameter logic [15:0] EXT_EDGE = 16'h00FF,
  parameter logic [15:0] EXT_POL  = 16'hF0F0,
  parameter int          ADDR_W   = 8,
  localparam int         LINES    = INT_LINES + NUM_EXT
) (
  input logic              clk,
  input logic              rst,
  input logic [LINES-1:0]  irq_in,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              irq_out,
  input logic [REG_W-1:0]  status_q,
  input logic [REG_W-1:0]  enable_q
);
  localparam logic [REG_W-1:0] VALID   = implemented_mask(LINES);
  localparam logic [REG_W-1:0] POL_ALL = {EXT_POL, 16'hFFFF};
  localparam logic [REG_W-1:0] EDG_ALL = {EXT_EDGE, 16'hFFFF};

  logic [REG_W-1:0] norm;
  logic [REG_W-1:0] ack_bits;
  assign norm     = REG_W'(irq_in) ^ ~POL_ALL;
  assign ack_bits = (bus_en && bus_we && bus_addr == ADDR_W'(OFS_ACK)) ? bus_wdata : '0;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_out && status_q == '0 && enable_q == '0)); // R1

  AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & ~$past(status_q) & EDG_ALL
                      & ~($past(norm) & ~$past(norm, 2))) == '0)); // R3

  AST_LEVEL_LATCHED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(norm) & ~EDG_ALL & VALID & ~status_q) == '0)); // R4

  AST_CLEAR_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~status_q & $past(status_q) & ~$past(ack_bits)) == '0)); // R5

  AST_OUT_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(status_q & enable_q))); // R8

  AST_RSVD_STAY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((status_q | enable_q) & ~VALID) == '0); // R9
endmodule

bind irq_collector irqc_checker #(
  .NUM_EXT(NUM_EXT), .EXT_EDGE(EXT_EDGE), .EXT_POL(EXT_POL), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
  .status_q(status_q), .enable_q(enable_q)
);

// File: tb/irq_collector_tb_top.sv
module irq_collector_tb_top;
  localparam int          NUM_EXT  = 16;
  localparam logic [15:0] EXT_EDGE = 16'h00FF;
  localparam logic [15:0] EXT_POL  = 16'hF0F0;
  localparam int          LINES    = 16 + NUM_EXT;

  localparam logic [7:0] A_STAT = 8'h30;
  localparam logic [7:0] A_PEND = 8'h34;
  localparam logic [7:0] A_ENAB = 8'h38;
  localparam logic [7:0] A_ACK  = 8'h3C;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LINES-1:0] irq_raw;
  logic             bus_en = 1'b0;
  logic             bus_we = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             irq_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_collector #(
    .NUM_EXT(NUM_EXT), .EXT_EDGE(EXT_EDGE), .EXT_POL(EXT_POL), .ADDR_W(8)
  ) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_raw), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic pol(input int i);
    if (i < 16) return 1'b1;
    return EXT_POL[i-16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int i, input bit asrt);
    @(negedge clk);
    irq_raw[i] = asrt ? pol(i) : ~pol(i);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v); chk("R1 status after reset", v, 32'h0);
    rd(A_ENAB, v); chk("R1 enable after reset", v, 32'h0);
    chk("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
    drive(3, 0);
    rd(A_STAT, v); chk("R1 no edge from held line", v, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    drive(3, 1);
    rd(A_STAT, v); chk("R3 rise latches", v, 32'h8);
    drive(3, 0);
    rd(A_STAT, v); chk("R3 bit kept after release", v, 32'h8);
    drive(4, 1);
    wr(A_ACK, 32'h18);
    rd(A_STAT, v); chk("R3 held edge line not relatched", v, 32'h0);
    drive(4, 0);
  endtask

  task automatic t_polarity;
    logic [31:0] v;
    drive(16, 1);
    rd(A_STAT, v); chk("R2 active-low edge falls to set", v, 32'h0001_0000);
    wr(A_ACK, 32'h0001_0000);
    drive(16, 0);
    rd(A_STAT, v); chk("R2 inactive move sets nothing", v, 32'h0);
    drive(20, 1);
    rd(A_STAT, v); chk("R2 active-high edge line", v, 32'h0010_0000);
    drive(20, 0);
    wr(A_ACK, 32'h0010_0000);
  endtask

  task automatic t_level;
    logic [31:0] v;
    drive(28, 1);
    rd(A_STAT, v); chk("R4 level line latched", v, 32'h1000_0000);
    wr(A_ACK, 32'h1000_0000);
    rd(A_STAT, v); chk("R6 level relatched after ack", v, 32'h1000_0000);
    drive(28, 0);
    wr(A_ACK, 32'h1000_0000);
    rd(A_STAT, v); chk("R4 level clears once released", v, 32'h0);
    drive(24, 1);
    rd(A_STAT, v); chk("R2 active-low level line", v, 32'h0100_0000);
    drive(24, 0);
    wr(A_ACK, 32'h0100_0000);
    rd(A_STAT, v); chk("R4 active-low level cleared", v, 32'h0);
  endtask

  task automatic t_ack_mask;
    logic [31:0] v;
    drive(5, 1); drive(5, 0);
    drive(12, 1); drive(12, 0);
    wr(A_ACK, 32'h0000_0840);
    rd(A_STAT, v); chk("R5 ack of clear bits no effect", v, 32'h0000_1020);
    wr(A_ACK, 32'h0000_0020);
    rd(A_STAT, v); chk("R5 ack clears only written bit", v, 32'h0000_1000);
    wr(A_ACK, 32'h0000_1000);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    drive(11, 1); drive(11, 0);
    chk("R8 masked line keeps output low", {31'b0, irq_out}, 32'h0);
    wr(A_ENAB, 32'h0000_0800);
    chk("R8 enable write raises output", {31'b0, irq_out}, 32'h1);
    rd(A_PEND, v); chk("R7 pending = status & enable", v, 32'h0000_0800);
    drive(12, 1); drive(12, 0);
    rd(A_PEND, v); chk("R7 disabled bit not pending", v, 32'h0000_0800);
    rd(A_ENAB, v); chk("R7 enable readback", v, 32'h0000_0800);
    wr(A_ENAB, 32'h0);
    chk("R8 enable clear drops output", {31'b0, irq_out}, 32'h0);
    rd(A_STAT, v); chk("R8 status kept while masked", v, 32'h0000_1800);
    wr(A_ACK, 32'hFFFF_FFFF);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr(A_ENAB, 32'hFFFF_FFFF);
    rd(A_ENAB, v); chk("R9 reserved enable bits read 0", v, 32'hBFFF_7878);
    drive(30, 1); drive(0, 1);
    rd(A_STAT, v); chk("R9 reserved lines never latch", v, 32'h0);
    chk("R9 output stays low", {31'b0, irq_out}, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R9 status not writable", v, 32'h0);
    rd(A_ACK, v); chk("R9 ack reads 0", v, 32'h0);
    drive(30, 0); drive(0, 0);
    wr(A_ENAB, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    drive(13, 1); drive(13, 0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h0000_6000;
    irq_raw[13] = 1'b1; irq_raw[14] = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    rd(A_STAT, v); chk("R10 event beats same-edge ack", v, 32'h0000_6000);
    drive(13, 0); drive(14, 0);
    wr(A_ACK, 32'h0000_6000);
    rd(A_STAT, v); chk("R5 cleared after collision", v, 32'h0);
  endtask

  task automatic t_read_latency;
    logic [31:0] v;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = A_STAT;
    irq_raw[6] = 1'b1;
    @(negedge clk);
    bus_en = 1'b0;
    chk("R11 read shows pre-edge state", bus_rdata, 32'h0);
    rd(A_STAT, v); chk("R11 next read shows new bit", v, 32'h0000_0040);
    drive(6, 0);
    wr(A_ACK, 32'h0000_0040);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) irq_raw[i] = ~pol(i);
    irq_raw[3] = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_edge();
    t_polarity();
    t_level();
    t_ack_mask();
    t_enable();
    t_reserved();
    t_collide();
    t_read_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule